// File: doc/BRIEF.md
# Home directory protocol controller

This block is the home-node engine of a flat, memory-based invalidation protocol. It takes one request message at a time (read, read-exclusive, upgrade, writeback, or one of two owner revision messages), looks up the directory entry for the addressed block, updates it, and emits the reply, forward and invalidation messages that the request calls for. Each entry holds a state, an owner pointer, a per-node presence vector and the identity of the requester waiting on a forwarded intervention. Data movement is represented only by message types. Nothing leaves the block as data.

While an intervention is outstanding, the entry sits in a busy state. Competing requests are refused with a negative acknowledgement. A writeback from the old owner that crosses the intervention is folded into the pending transaction. The writer's data goes on to the waiting requester, and the entry settles in its final state. The output port uses a valid/ready handshake. A new request is taken only after every message of the current one has been handed over.

Directory states: unowned, shared, exclusive, busy-shared (a read is waiting on the owner) and busy-exclusive (a read-exclusive is waiting on the owner). Controller states: IDLE accepts a request. EVAL applies the protocol rule and writes the entry. SEND1 and SEND2 deliver the first and second fixed messages. INVAL delivers invalidations. The transitions are: IDLE→EVAL on accept; EVAL→SEND1 when the rule yields a message, EVAL→IDLE when it yields none; SEND1→SEND2, INVAL or IDLE on handshake; SEND2→INVAL or IDLE on handshake; INVAL→IDLE when the last invalidation is taken.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is unowned, in_ready is 1 and out_valid is 0.
- R2: A read (in_type 0), read-exclusive (1) or upgrade (2) to a block in busy-shared or busy-exclusive produces exactly one message: NACK (out_type 10) to the requester. The entry is left unchanged.
- R3: A read to an unowned block produces one DATA message (out_type 1) to the requester. The entry becomes exclusive, with the requester as owner.
- R4: A read to a shared block adds the requester to the presence vector. It produces one DATA message (out_type 1) and nothing else.
- R5: A read to an exclusive block sets busy-shared. A read-exclusive to an exclusive block sets busy-exclusive. Either one sends a speculative reply (out_type 4) to the requester and then an intervention to the owner, with out_arg set to the requester. The intervention is out_type 5 for a read and 6 for a read-exclusive.
- R6: A read-exclusive to a shared block replies DATA_EXCL (out_type 2) to the requester, with out_arg equal to the number of other sharers. It then sends INVAL (out_type 7, out_arg = requester) to each other sharer, in ascending node order. The entry becomes exclusive, with the requester as owner. A read-exclusive to an unowned block gives DATA_EXCL with out_arg 0.
- R7: An upgrade to an unowned or exclusive block gets a NACK (out_type 10). An upgrade to a shared block gets UPG_ACK (out_type 3) with the other-sharer count in out_arg, followed by invalidations as in R6.
- R8: A writeback (in_type 3) from the owner of an exclusive block makes the block unowned and returns WB_ACK (out_type 8). A writeback in any other non-busy case returns only WB_ACK and leaves the entry unchanged.
- R9: A writeback to a busy-shared block resolves it to shared, with only the pending requester present. A writeback to a busy-exclusive block resolves it to exclusive, owned by the pending requester. Both send WB_DATA (out_type 9, out_arg = writer) to the pending requester, then WB_ACK to the writer.
- R10: A sharing writeback (in_type 4) moves busy-shared to shared, with owner and requester present. An ownership transfer (in_type 5) moves busy-exclusive to exclusive, owned by the requester. Neither sends a message. Either one in any other state is ignored.
- R11: out_valid and the message fields hold until out_ready. in_ready stays 0 from the acceptance of a request until its last message has been taken. Every message carries the request's block index in out_blk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request message present |
| in_ready | output | 1 | Controller can take a request |
| in_type | input | 3 | Request kind |
| in_src | input | NODE_W | Sending node |
| in_blk | input | BLK_W | Block index |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Receiver takes the message |
| out_type | output | 4 | Message kind |
| out_dst | output | NODE_W | Destination node |
| out_blk | output | BLK_W | Block index |
| out_arg | output | NODE_W | Requester ID or ack count |

## Verification
The hardest situation to reach is a writeback that arrives while its block is busy, with the intervention still outstanding. Reaching it takes a chain: a grant of ownership, a competing read or read-exclusive from another node, then a writeback from the old owner before its revision message. Directed sequences build this chain for both busy flavours, and also a shared block with all eight nodes present. Random traffic over only four blocks and eight nodes makes these collisions recur. Random out_ready gaps exercise the hold rule on the output port.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

    typedef enum logic [2:0] {
        REQ_RD   = 3'd0,
        REQ_RDX  = 3'd1,
        REQ_UPG  = 3'd2,
        REQ_WB   = 3'd3,
        REQ_SHWB = 3'd4,
        REQ_XFER = 3'd5
    } req_e;

    typedef enum logic [3:0] {
        RSP_NONE     = 4'd0,
        RSP_DATA     = 4'd1,
        RSP_DATA_EX  = 4'd2,
        RSP_UPG_ACK  = 4'd3,
        RSP_SPEC     = 4'd4,
        RSP_FWD_RD   = 4'd5,
        RSP_FWD_RDX  = 4'd6,
        RSP_INVAL    = 4'd7,
        RSP_WB_ACK   = 4'd8,
        RSP_WB_DATA  = 4'd9,
        RSP_NACK     = 4'd10
    } rsp_e;

    typedef enum logic [2:0] {
        DS_UNOWNED = 3'd0,
        DS_SHARED  = 3'd1,
        DS_EXCL    = 3'd2,
        DS_BUSY_SH = 3'd3,
        DS_BUSY_EX = 3'd4
    } dstate_e;

    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_EVAL  = 3'd1,
        F_SEND1 = 3'd2,
        F_SEND2 = 3'd3,
        F_INVAL = 3'd4
    } fsm_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
    import dir_home_pkg::*;
#(
    parameter int NODES   = 8,
    parameter int NUM_BLK = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  rd_idx,
    output dstate_e           rd_state,
    output logic [NODE_W-1:0] rd_owner,
    output logic [NODES-1:0]  rd_pres,
    output logic [NODE_W-1:0] rd_pend,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_idx,
    input  dstate_e           wr_state,
    input  logic [NODE_W-1:0] wr_owner,
    input  logic [NODES-1:0]  wr_pres,
    input  logic [NODE_W-1:0] wr_pend
);

    dstate_e           st_q   [NUM_BLK];
    logic [NODE_W-1:0] own_q  [NUM_BLK];
    logic [NODES-1:0]  pres_q [NUM_BLK];
    logic [NODE_W-1:0] pend_q [NUM_BLK];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= DS_UNOWNED;
                own_q[g]  <= '0;
                pres_q[g] <= '0;
                pend_q[g] <= '0;
            end else if (wr_en && (wr_idx == BLK_W'(g))) begin
                st_q[g]   <= wr_state;
                own_q[g]  <= wr_owner;
                pres_q[g] <= wr_pres;
                pend_q[g] <= wr_pend;
            end
        end
    end

    assign rd_state = st_q[rd_idx];
    assign rd_owner = own_q[rd_idx];
    assign rd_pres  = pres_q[rd_idx];
    assign rd_pend  = pend_q[rd_idx];

endmodule

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
    parameter int NODES   = 8,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic [NODES-1:0]  mask,
    output logic [NODE_W-1:0] idx,
    output logic              any
);

    always_comb begin
        idx = '0;
        any = |mask;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (mask[i]) idx = NODE_W'(i);
        end
    end

endmodule

// File: rtl/dir_rules.sv
module dir_rules
    import dir_home_pkg::*;
#(
    parameter int NODES   = 8,
    localparam int NODE_W = $clog2(NODES)
) (
    input  req_e              req_type,
    input  logic [NODE_W-1:0] req_src,
    input  dstate_e           cur_state,
    input  logic [NODE_W-1:0] cur_owner,
    input  logic [NODES-1:0]  cur_pres,
    input  logic [NODE_W-1:0] cur_pend,
    output dstate_e           nx_state,
    output logic [NODE_W-1:0] nx_owner,
    output logic [NODES-1:0]  nx_pres,
    output logic [NODE_W-1:0] nx_pend,
    output logic              m1_vld,
    output rsp_e              m1_type,
    output logic [NODE_W-1:0] m1_dst,
    output logic [NODE_W-1:0] m1_arg,
    output logic              m2_vld,
    output rsp_e              m2_type,
    output logic [NODE_W-1:0] m2_dst,
    output logic [NODE_W-1:0] m2_arg,
    output logic [NODES-1:0]  inv_mask
);

    function automatic logic [NODES-1:0] one_hot(input logic [NODE_W-1:0] n);
        logic [NODES-1:0] v;
        v    = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    function automatic logic [NODE_W-1:0] count_set(input logic [NODES-1:0] v);
        logic [NODE_W-1:0] c;
        c = '0;
        for (int i = 0; i < NODES; i++) c = c + NODE_W'(v[i]);
        return c;
    endfunction

    logic [NODES-1:0] others;

    always_comb begin
        nx_state = cur_state;
        nx_owner = cur_owner;
        nx_pres  = cur_pres;
        nx_pend  = cur_pend;
        m1_vld   = 1'b0;
        m1_type  = RSP_NONE;
        m1_dst   = req_src;
        m1_arg   = '0;
        m2_vld   = 1'b0;
        m2_type  = RSP_NONE;
        m2_dst   = '0;
        m2_arg   = '0;
        inv_mask = '0;
        others   = cur_pres & ~one_hot(req_src);

        unique case (req_type)
            REQ_RD: begin
                m1_vld = 1'b1;
                unique case (cur_state)
                    DS_UNOWNED: begin
                        nx_state = DS_EXCL;
                        nx_owner = req_src;
                        nx_pres  = one_hot(req_src);
                        m1_type  = RSP_DATA;
                    end
                    DS_SHARED: begin
                        nx_pres = cur_pres | one_hot(req_src);
                        m1_type = RSP_DATA;
                    end
                    DS_EXCL: begin
                        nx_state = DS_BUSY_SH;
                        nx_pend  = req_src;
                        nx_pres  = cur_pres | one_hot(req_src);
                        m1_type  = RSP_SPEC;
                        m2_vld   = 1'b1;
                        m2_type  = RSP_FWD_RD;
                        m2_dst   = cur_owner;
                        m2_arg   = req_src;
                    end
                    default: m1_type = RSP_NACK;
                endcase
            end
            REQ_RDX, REQ_UPG: begin
                m1_vld = 1'b1;
                unique case (cur_state)
                    DS_SHARED: begin
                        nx_state = DS_EXCL;
                        nx_owner = req_src;
                        nx_pres  = one_hot(req_src);
                        m1_type  = (req_type == REQ_RDX) ? RSP_DATA_EX : RSP_UPG_ACK;
                        m1_arg   = count_set(others);
                        inv_mask = others;
                    end
                    DS_UNOWNED: begin
                        if (req_type == REQ_RDX) begin
                            nx_state = DS_EXCL;
                            nx_owner = req_src;
                            nx_pres  = one_hot(req_src);
                            m1_type  = RSP_DATA_EX;
                        end else begin
                            m1_type = RSP_NACK;
                        end
                    end
                    DS_EXCL: begin
                        if (req_type == REQ_RDX) begin
                            nx_state = DS_BUSY_EX;
                            nx_pend  = req_src;
                            m1_type  = RSP_SPEC;
                            m2_vld   = 1'b1;
                            m2_type  = RSP_FWD_RDX;
                            m2_dst   = cur_owner;
                            m2_arg   = req_src;
                        end else begin
                            m1_type = RSP_NACK;
                        end
                    end
                    default: m1_type = RSP_NACK;
                endcase
            end
            REQ_WB: begin
                m1_vld = 1'b1;
                unique case (cur_state)
                    DS_EXCL: begin
                        m1_type = RSP_WB_ACK;
                        if (req_src == cur_owner) begin
                            nx_state = DS_UNOWNED;
                            nx_pres  = '0;
                        end
                    end
                    DS_BUSY_SH, DS_BUSY_EX: begin
                        nx_state = (cur_state == DS_BUSY_SH) ? DS_SHARED : DS_EXCL;
                        nx_owner = cur_pend;
                        nx_pres  = one_hot(cur_pend);
                        m1_type  = RSP_WB_DATA;
                        m1_dst   = cur_pend;
                        m1_arg   = req_src;
                        m2_vld   = 1'b1;
                        m2_type  = RSP_WB_ACK;
                        m2_dst   = req_src;
                    end
                    default: m1_type = RSP_WB_ACK;
                endcase
            end
            REQ_SHWB: begin
                if (cur_state == DS_BUSY_SH) begin
                    nx_state = DS_SHARED;
                    nx_pres  = one_hot(cur_owner) | one_hot(cur_pend);
                end
            end
            REQ_XFER: begin
                if (cur_state == DS_BUSY_EX) begin
                    nx_state = DS_EXCL;
                    nx_owner = cur_pend;
                    nx_pres  = one_hot(cur_pend);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_home_pkg::*;
#(
    parameter int NODES   = 8,
    parameter int NUM_BLK = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_type,
    input  logic [NODE_W-1:0] in_src,
    input  logic [BLK_W-1:0]  in_blk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3:0]        out_type,
    output logic [NODE_W-1:0] out_dst,
    output logic [BLK_W-1:0]  out_blk,
    output logic [NODE_W-1:0] out_arg
);

    fsm_e fsm_q, fsm_d;

    logic [2:0]        lat_type;
    logic [NODE_W-1:0] lat_src;
    logic [BLK_W-1:0]  lat_blk;

    dstate_e           e_state;
    logic [NODE_W-1:0] e_owner, e_pend;
    logic [NODES-1:0]  e_pres;

    dstate_e           n_state;
    logic [NODE_W-1:0] n_owner, n_pend;
    logic [NODES-1:0]  n_pres;

    logic              r1_vld, r2_vld;
    rsp_e              r1_type, r2_type;
    logic [NODE_W-1:0] r1_dst, r1_arg, r2_dst, r2_arg;
    logic [NODES-1:0]  r_inv;

    logic              m1_vld_q, m2_vld_q;
    rsp_e              m1_type_q, m2_type_q;
    logic [NODE_W-1:0] m1_dst_q, m1_arg_q, m2_dst_q, m2_arg_q;
    logic [NODES-1:0]  inv_q;

    logic [NODE_W-1:0] pick_idx;
    logic              pick_any;
    logic              inv_last;
    logic              take;

    dir_entry_store #(.NODES(NODES), .NUM_BLK(NUM_BLK)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lat_blk),
        .rd_state (e_state),
        .rd_owner (e_owner),
        .rd_pres  (e_pres),
        .rd_pend  (e_pend),
        .wr_en    (fsm_q == F_EVAL),
        .wr_idx   (lat_blk),
        .wr_state (n_state),
        .wr_owner (n_owner),
        .wr_pres  (n_pres),
        .wr_pend  (n_pend)
    );

    dir_rules #(.NODES(NODES)) i_rules (
        .req_type  (req_e'(lat_type)),
        .req_src   (lat_src),
        .cur_state (e_state),
        .cur_owner (e_owner),
        .cur_pres  (e_pres),
        .cur_pend  (e_pend),
        .nx_state  (n_state),
        .nx_owner  (n_owner),
        .nx_pres   (n_pres),
        .nx_pend   (n_pend),
        .m1_vld    (r1_vld),
        .m1_type   (r1_type),
        .m1_dst    (r1_dst),
        .m1_arg    (r1_arg),
        .m2_vld    (r2_vld),
        .m2_type   (r2_type),
        .m2_dst    (r2_dst),
        .m2_arg    (r2_arg),
        .inv_mask  (r_inv)
    );

    dir_lowest_pick #(.NODES(NODES)) i_pick (
        .mask (inv_q),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    assign take     = out_valid && out_ready;
    assign inv_last = (inv_q & (inv_q - NODES'(1))) == '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= F_IDLE;
        else        fsm_q <= fsm_d;
    end

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            F_IDLE:  if (in_valid) fsm_d = F_EVAL;
            F_EVAL:  fsm_d = r1_vld ? F_SEND1 : F_IDLE;
            F_SEND1: if (out_ready) fsm_d = m2_vld_q ? F_SEND2 : ((|inv_q) ? F_INVAL : F_IDLE);
            F_SEND2: if (out_ready) fsm_d = (|inv_q) ? F_INVAL : F_IDLE;
            F_INVAL: if (out_ready && inv_last) fsm_d = F_IDLE;
            default: fsm_d = F_IDLE;
        endcase
    end

    // request latch and message registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_type  <= '0;
            lat_src   <= '0;
            lat_blk   <= '0;
            m1_vld_q  <= 1'b0;
            m2_vld_q  <= 1'b0;
            m1_type_q <= RSP_NONE;
            m2_type_q <= RSP_NONE;
            m1_dst_q  <= '0;
            m1_arg_q  <= '0;
            m2_dst_q  <= '0;
            m2_arg_q  <= '0;
            inv_q     <= '0;
        end else begin
            if (fsm_q == F_IDLE && in_valid) begin
                lat_type <= in_type;
                lat_src  <= in_src;
                lat_blk  <= in_blk;
            end
            if (fsm_q == F_EVAL) begin
                m1_vld_q  <= r1_vld;
                m1_type_q <= r1_type;
                m1_dst_q  <= r1_dst;
                m1_arg_q  <= r1_arg;
                m2_vld_q  <= r2_vld;
                m2_type_q <= r2_type;
                m2_dst_q  <= r2_dst;
                m2_arg_q  <= r2_arg;
                inv_q     <= r_inv;
            end
            if (fsm_q == F_INVAL && take && pick_any) begin
                inv_q[pick_idx] <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_type  = 4'(RSP_NONE);
        out_dst   = '0;
        out_arg   = '0;
        out_blk   = lat_blk;
        unique case (fsm_q)
            F_IDLE:  in_ready = 1'b1;
            F_EVAL:  ;
            F_SEND1: begin
                out_valid = 1'b1;
                out_type  = 4'(m1_type_q);
                out_dst   = m1_dst_q;
                out_arg   = m1_arg_q;
            end
            F_SEND2: begin
                out_valid = 1'b1;
                out_type  = 4'(m2_type_q);
                out_dst   = m2_dst_q;
                out_arg   = m2_arg_q;
            end
            F_INVAL: begin
                out_valid = 1'b1;
                out_type  = 4'(RSP_INVAL);
                out_dst   = pick_idx;
                out_arg   = lat_src;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
    parameter int NODES   = 8,
    parameter int NUM_BLK = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_type,
    input logic [NODE_W-1:0] in_src,
    input logic [BLK_W-1:0]  in_blk,
    input logic              out_valid,
    input logic              out_ready,
    input logic [3:0]        out_type,
    input logic [NODE_W-1:0] out_dst,
    input logic [BLK_W-1:0]  out_blk,
    input logic [NODE_W-1:0] out_arg
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_ready && !out_valid)); // R1

    AST_NACK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_type == 4'd10) |=> in_ready); // R2

    AST_INVAL_NOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == 4'd7) |-> (out_dst != out_arg)); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_dst)
                                       && $stable(out_arg) && $stable(out_blk))); // R11

    AST_NO_ACCEPT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R11

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R11

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .NUM_BLK(NUM_BLK)) i_dir_home_chk (.*);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;

    localparam int NODES   = 8;
    localparam int NUM_BLK = 16;
    localparam int NODE_W  = $clog2(NODES);
    localparam int BLK_W   = $clog2(NUM_BLK);

    // bench-side encodings taken from the requirements
    localparam int UN = 0, SH = 1, EX = 2, BSH = 3, BEX = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [2:0]        in_type = '0;
    logic [NODE_W-1:0] in_src = '0;
    logic [BLK_W-1:0]  in_blk = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [3:0]        out_type;
    logic [NODE_W-1:0] out_dst;
    logic [BLK_W-1:0]  out_blk;
    logic [NODE_W-1:0] out_arg;

    always #10 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .NUM_BLK(NUM_BLK)) i_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
        .in_src(in_src), .in_blk(in_blk),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
        .out_dst(out_dst), .out_blk(out_blk), .out_arg(out_arg)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cyc      = 0;

    int m_st   [NUM_BLK];
    int m_own  [NUM_BLK];
    int m_pres [NUM_BLK];
    int m_pend [NUM_BLK];

    int    exp_t [16];
    int    exp_d [16];
    int    exp_a [16];
    string exp_r [16];
    int    n_exp;

    task automatic check(input bit ok, input string req, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic push(input int ty, input int d, input int a, input string r);
        exp_t[n_exp] = ty;
        exp_d[n_exp] = d;
        exp_a[n_exp] = a;
        exp_r[n_exp] = r;
        n_exp++;
    endtask

    function automatic int popc(input int v);
        int c = 0;
        for (int i = 0; i < NODES; i++) if (v[i]) c++;
        return c;
    endfunction

    task automatic claim_excl(input int b, input int s, input int ty, input string r);
        int others = m_pres[b] & ~(1 << s);
        push(ty, s, popc(others), r);
        for (int n = 0; n < NODES; n++) if (others[n]) push(7, n, s, r);
        m_st[b] = EX; m_own[b] = s; m_pres[b] = 1 << s;
    endtask

    // expected behaviour per the requirements
    task automatic model(input int t, input int s, input int b);
        n_exp = 0;
        case (t)
            0: case (m_st[b])
                UN: begin m_st[b] = EX; m_own[b] = s; m_pres[b] = 1 << s; push(1, s, 0, "R3"); end
                SH: begin m_pres[b] |= 1 << s; push(1, s, 0, "R4"); end
                EX: begin m_st[b] = BSH; m_pend[b] = s; push(4, s, 0, "R5"); push(5, m_own[b], s, "R5"); end
                default: push(10, s, 0, "R2");
            endcase
            1: case (m_st[b])
                UN: begin m_st[b] = EX; m_own[b] = s; m_pres[b] = 1 << s; push(2, s, 0, "R6"); end
                SH: claim_excl(b, s, 2, "R6");
                EX: begin m_st[b] = BEX; m_pend[b] = s; push(4, s, 0, "R5"); push(6, m_own[b], s, "R5"); end
                default: push(10, s, 0, "R2");
            endcase
            2: case (m_st[b])
                SH: claim_excl(b, s, 3, "R7");
                BSH, BEX: push(10, s, 0, "R2");
                default: push(10, s, 0, "R7");
            endcase
            3: case (m_st[b])
                EX: begin
                    if (s == m_own[b]) begin m_st[b] = UN; m_pres[b] = 0; end
                    push(8, s, 0, "R8");
                end
                BSH, BEX: begin
                    push(9, m_pend[b], s, "R9");
                    push(8, s, 0, "R9");
                    m_st[b] = (m_st[b] == BSH) ? SH : EX;
                    m_own[b] = m_pend[b];
                    m_pres[b] = 1 << m_pend[b];
                end
                default: push(8, s, 0, "R8");
            endcase
            4: if (m_st[b] == BSH) begin
                m_st[b] = SH; m_pres[b] = (1 << m_own[b]) | (1 << m_pend[b]);
            end
            5: if (m_st[b] == BEX) begin
                m_st[b] = EX; m_own[b] = m_pend[b]; m_pres[b] = 1 << m_pend[b];
            end
            default: ;
        endcase
    endtask

    task automatic do_req(input int t, input int s, input int b);
        int got = 0;
        model(t, s, b);
        in_type  = 3'(t);
        in_src   = NODE_W'(s);
        in_blk   = BLK_W'(b);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        forever begin
            out_ready = ($urandom % 4) != 0;
            #1;
            if (out_valid && out_ready) begin
                if (got < n_exp) begin
                    check(int'(out_type) == exp_t[got] && int'(out_dst) == exp_d[got]
                          && int'(out_arg) == exp_a[got] && int'(out_blk) == b, exp_r[got],
                          $sformatf("type/dst/arg/blk got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                                    out_type, out_dst, out_arg, out_blk,
                                    exp_t[got], exp_d[got], exp_a[got], b));
                end
                got++;
            end
            if (in_ready) break;
            @(negedge clk);
        end
        // R11: in_ready returns only after all messages; R10 covers the zero-message case
        check(got == n_exp, (n_exp == 0) ? "R10" : "R11",
              $sformatf("message count got %0d expected %0d", got, n_exp));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R11: watchdog, got hung controller, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < NUM_BLK; i++) begin
            m_st[i] = UN; m_own[i] = 0; m_pres[i] = 0; m_pend[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1",
              $sformatf("in_ready/out_valid got %0d/%0d expected 1/0", in_ready, out_valid));

        // directed: busy flow with crossing of revision, then R2 NACKs
        do_req(0, 2, 8);   // R3 (R1: fresh entry unowned)
        do_req(0, 3, 8);   // R5 busy-shared
        do_req(1, 4, 8);   // R2
        do_req(2, 5, 8);   // R2
        do_req(0, 6, 8);   // R2
        do_req(4, 2, 8);   // R10 sharing writeback
        do_req(0, 6, 8);   // R4
        do_req(2, 3, 8);   // R7 upgrade with two invalidations
        do_req(1, 1, 8);   // R5 busy-exclusive
        do_req(3, 3, 8);   // R9 crossing writeback
        do_req(3, 1, 8);   // R8
        do_req(2, 0, 8);   // R7 upgrade to unowned
        do_req(5, 0, 8);   // R10 ignored transfer
        do_req(0, 7, 8);   // R3 confirms still unowned
        do_req(1, 0, 9);   // R6 unowned read-exclusive
        do_req(3, 5, 9);   // R8 stale writeback
        do_req(0, 3, 9);   // R5
        do_req(3, 0, 9);   // R9 crossing into busy-shared
        do_req(1, 4, 11);  // R6
        do_req(0, 2, 11);  // R5
        do_req(5, 4, 11);  // R10 wrong revision ignored
        do_req(0, 6, 11);  // R2 still busy
        // all nodes sharing, then a full invalidation fan-out
        do_req(0, 0, 10);
        do_req(0, 1, 10);
        do_req(4, 0, 10);
        for (int n = 2; n < NODES; n++) do_req(0, n, 10);
        do_req(1, 7, 10);  // R6 count 7
        do_req(1, 2, 12);
        do_req(1, 5, 12);
        do_req(5, 2, 12);  // R10 transfer
        do_req(3, 5, 12);  // R8

        // constrained random over a few hot blocks
        for (int k = 0; k < 1500; k++) begin
            do_req($urandom % 6, $urandom % NODES, $urandom % 4);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule